// File: doc/BRIEF.md
# Write-back update coherence controller

This block keeps one private cache coherent on a snooping shared bus. It uses an update policy rather than an invalidate policy. A valid line is always in one of four states: exclusive-clean, modified, shared-clean or shared-modified. Lines that are not held are simply absent from the tag array, so there is no invalid state. When a processor writes a shared line, the new word is broadcast to the other caches and memory is left untouched. Among the sharers, only the cache in shared-modified is responsible for eventually writing the block back.

The controller owns a small direct-mapped array that holds tag, coherence state and data for each line. Processor reads and writes arrive one at a time, and the controller runs them against this array. When it needs the bus, it issues a line read, a word update or a line write-back, and holds that request until the bus grants it. At the moment of the grant it samples the bus shared wire, which tells it whether the line is exclusive or shared. In the other direction, snooped bus reads and bus updates are checked against the array. For each one the controller drives the shared wire, supplies the whole line when it holds dirty data, and absorbs words that other caches have updated.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset no line is present, `cpu_ready` is high, and `bus_req`, `cpu_done` and `snp_flush` are low. A snoop of any address reports no sharing.
- R2: A read miss issues a bus read (command code 1) with the line-aligned address. The line is filled from `bus_fill_line`, where word i sits at bits [i*WORD_W +: WORD_W]. The filled line is shared-clean if `bus_shared` was high at the grant and exclusive-clean otherwise. A request is held with a stable command and address until it is granted.
- R3: A read hit returns the addressed word on `cpu_rdata` with a one-cycle `cpu_done` pulse, and uses no bus transaction.
- R4: A write to an exclusive-clean or modified line stores the word and leaves the line modified, with no bus transaction.
- R5: A write to a shared-clean or shared-modified line issues a bus update (code 2) that carries the word address and the word. The word is stored at the grant. The line becomes shared-modified if `bus_shared` is high at the grant, and modified otherwise.
- R6: A snooped read (code 1) that hits a modified or shared-modified line pulses `snp_flush` one cycle later with the full line. The line then stays in, or moves to, shared-modified.
- R7: A snooped read that hits an exclusive-clean line moves it to shared-clean without a flush. `snp_hit_shared` is high in the same cycle as any snoop that hits.
- R8: A snooped update (code 2) that hits a shared line stores the incoming word. A shared-modified line drops to shared-clean, which ends its write-back duty.
- R9: A miss whose victim line is modified or shared-modified first writes the victim back (code 3, victim line address and data). The bus read follows immediately. A clean victim is dropped without any bus action.
- R10: A snoop that misses the array produces no sharing indication and no flush, and leaves the stored data unchanged.
- R11: While `snp_valid` is high the processor lookup waits. The bus never grants in a cycle that carries a snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Write word |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read result, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 1 read, 2 update, 3 write-back |
| bus_addr | output | ADDR_W | Line address (read, write-back) or word address (update) |
| bus_wdata | output | WORD_W | Update word |
| bus_wb_line | output | WORD_W*WORDS | Write-back line data |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared | input | 1 | Another cache holds the line, sampled at the grant |
| bus_fill_line | input | WORD_W*WORDS | Line data for a bus read, valid at the grant |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | 1 read, 2 update |
| snp_addr | input | ADDR_W | Snooped word address |
| snp_word | input | WORD_W | Snooped update word |
| snp_hit_shared | output | 1 | This cache holds the snooped line (drives the shared wire) |
| snp_flush | output | 1 | Line supplied for the previous snooped read |
| snp_flush_line | output | WORD_W*WORDS | Supplied line data |

## Verification
The coherence state never leaves the block, so a wrong state shows up only through the bus traffic it causes later. A line wrongly left exclusive produces no update on the next write. A line that lost its dirty duty skips the flush on the next snooped read and the write-back on replacement. A line wrongly marked dirty produces an extra flush or write-back. Each scenario therefore follows a state-changing event with the cheapest probe that exposes the state: a write, a snooped read, or a conflicting miss. The error appears within that single probe, a few cycles after the event.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;

   typedef enum logic [1:0] {
      CS_EXCL  = 2'd0,
      CS_SHCLN = 2'd1,
      CS_SHMOD = 2'd2,
      CS_MOD   = 2'd3
   } coh_state_e;

   typedef enum logic [1:0] {
      BC_NONE   = 2'd0,
      BC_READ   = 2'd1,
      BC_UPDATE = 2'd2,
      BC_WRBACK = 2'd3
   } bus_cmd_e;

   function automatic logic st_dirty(coh_state_e s);
      return (s == CS_MOD) || (s == CS_SHMOD);
   endfunction

   function automatic logic st_shared(coh_state_e s);
      return (s == CS_SHCLN) || (s == CS_SHMOD);
   endfunction

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
   import upd_coh_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int TAG_W  = 8,
   parameter int WORD_W = 32,
   parameter int WORDS  = 4,
   localparam int IDX_W  = $clog2(LINES),
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LINE_W = WORD_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic              ra_present,
   output logic [TAG_W-1:0]  ra_tag,
   output coh_state_e        ra_state,
   output logic [LINE_W-1:0] ra_line,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic              rb_present,
   output logic [TAG_W-1:0]  rb_tag,
   output coh_state_e        rb_state,
   output logic [LINE_W-1:0] rb_line,
   input  logic              w_en,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic              w_meta_en,
   input  logic              w_present,
   input  logic [TAG_W-1:0]  w_tag,
   input  coh_state_e        w_state,
   input  logic              w_line_en,
   input  logic [LINE_W-1:0] w_line,
   input  logic              w_word_en,
   input  logic [OFF_W-1:0]  w_off,
   input  logic [WORD_W-1:0] w_word
);

   logic [LINES-1:0]  pres_v;
   logic [TAG_W-1:0]  tag_v  [LINES];
   coh_state_e        st_v   [LINES];
   logic [LINE_W-1:0] data_v [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic              pres_q;
      logic [TAG_W-1:0]  tag_q;
      coh_state_e        st_q;
      logic [LINE_W-1:0] data_q;
      logic              sel;

      assign sel = w_en && (w_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pres_q <= 1'b0;
            tag_q  <= '0;
            st_q   <= CS_EXCL;
            data_q <= '0;
         end else if (sel) begin
            if (w_meta_en) begin
               pres_q <= w_present;
               tag_q  <= w_tag;
               st_q   <= w_state;
            end
            if (w_line_en)
               data_q <= w_line;
            else if (w_word_en)
               data_q[w_off*WORD_W +: WORD_W] <= w_word;
         end
      end

      assign pres_v[g] = pres_q;
      assign tag_v[g]  = tag_q;
      assign st_v[g]   = st_q;
      assign data_v[g] = data_q;
   end

   assign ra_present = pres_v[ra_idx];
   assign ra_tag     = tag_v[ra_idx];
   assign ra_state   = st_v[ra_idx];
   assign ra_line    = data_v[ra_idx];
   assign rb_present = pres_v[rb_idx];
   assign rb_tag     = tag_v[rb_idx];
   assign rb_state   = st_v[rb_idx];
   assign rb_line    = data_v[rb_idx];

   // R2: a whole-line fill always makes the line present
   a_r2_fill_present: assert property (@(posedge clk) disable iff (!rst_n)
      (w_en && w_meta_en && w_line_en) |-> w_present);

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
   import upd_coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int WORD_W = 32,
   parameter int WORDS  = 4,
   parameter int LINES  = 4,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int IDX_W  = $clog2(LINES),
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
   localparam int LINE_W = WORD_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [WORD_W-1:0] snp_word,
   output logic [IDX_W-1:0]  rb_idx,
   input  logic              rb_present,
   input  logic [TAG_W-1:0]  rb_tag,
   input  coh_state_e        rb_state,
   input  logic [LINE_W-1:0] rb_line,
   output logic              sw_en,
   output logic              sw_meta_en,
   output coh_state_e        sw_state,
   output logic              sw_word_en,
   output logic [OFF_W-1:0]  sw_off,
   output logic [WORD_W-1:0] sw_word,
   output logic              snp_hit_shared,
   output logic              snp_flush,
   output logic [LINE_W-1:0] snp_flush_line
);

   logic [TAG_W-1:0] s_tag;
   logic             hit, is_rd, is_up, give_line;

   assign s_tag  = snp_addr[ADDR_W-1 -: TAG_W];
   assign rb_idx = snp_addr[OFF_W +: IDX_W];
   assign sw_off = snp_addr[OFF_W-1:0];
   assign sw_word = snp_word;
   assign is_rd  = (snp_cmd == BC_READ);
   assign is_up  = (snp_cmd == BC_UPDATE);
   assign hit    = snp_valid && rb_present && (rb_tag == s_tag);
   assign snp_hit_shared = hit;
   assign give_line = hit && is_rd && st_dirty(rb_state);

   always_comb begin
      sw_meta_en = 1'b0;
      sw_word_en = 1'b0;
      sw_state   = rb_state;
      if (hit && is_rd) begin
         unique case (rb_state)
            CS_MOD:  begin sw_meta_en = 1'b1; sw_state = CS_SHMOD; end
            CS_EXCL: begin sw_meta_en = 1'b1; sw_state = CS_SHCLN; end
            default: ;
         endcase
      end else if (hit && is_up && st_shared(rb_state)) begin
         sw_word_en = 1'b1;
         sw_meta_en = 1'b1;
         sw_state   = CS_SHCLN;
      end
      sw_en = sw_meta_en || sw_word_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snp_flush      <= 1'b0;
         snp_flush_line <= '0;
      end else begin
         snp_flush <= give_line;
         if (give_line) snp_flush_line <= rb_line;
      end
   end

   // R6: a flush answers only a snooped read of the previous cycle
   a_r6_flush_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> $past(snp_valid && (snp_cmd == BC_READ)));

   // R10: without a snoop there is no flush in the following cycle
   a_r10_quiet_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_valid |=> !snp_flush);

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
   import upd_coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int WORD_W = 32,
   parameter int WORDS  = 4,
   parameter int LINES  = 4,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int IDX_W  = $clog2(LINES),
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
   localparam int LINE_W = WORD_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic [WORD_W-1:0] cpu_rdata,
   input  logic              stall,
   output logic [IDX_W-1:0]  ra_idx,
   input  logic              ra_present,
   input  logic [TAG_W-1:0]  ra_tag,
   input  coh_state_e        ra_state,
   input  logic [LINE_W-1:0] ra_line,
   output logic              bus_req,
   output bus_cmd_e          bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [WORD_W-1:0] bus_wdata,
   output logic [LINE_W-1:0] bus_wb_line,
   input  logic              bus_gnt,
   input  logic              bus_shared,
   input  logic [LINE_W-1:0] bus_fill_line,
   output logic              fw_en,
   output logic              fw_meta_en,
   output logic              fw_present,
   output logic [TAG_W-1:0]  fw_tag,
   output coh_state_e        fw_state,
   output logic              fw_line_en,
   output logic [LINE_W-1:0] fw_line,
   output logic              fw_word_en,
   output logic [OFF_W-1:0]  fw_off,
   output logic [WORD_W-1:0] fw_word
);

   typedef enum logic [2:0] {F_IDLE, F_LOOK, F_UPD, F_WB, F_FILL} fsm_e;

   fsm_e              st_q;
   logic              q_we;
   logic [ADDR_W-1:0] q_addr;
   logic [WORD_W-1:0] q_wdata;
   logic [TAG_W-1:0]  q_tag;
   logic [OFF_W-1:0]  q_off;
   logic              look_hit, own_line;

   assign q_tag     = q_addr[ADDR_W-1 -: TAG_W];
   assign ra_idx    = q_addr[OFF_W +: IDX_W];
   assign q_off     = q_addr[OFF_W-1:0];
   assign look_hit  = ra_present && (ra_tag == q_tag);
   assign own_line  = (ra_state == CS_EXCL) || (ra_state == CS_MOD);
   assign cpu_ready = (st_q == F_IDLE);

   always_comb begin
      bus_req     = 1'b1;
      bus_cmd     = BC_NONE;
      bus_addr    = {q_tag, ra_idx, {OFF_W{1'b0}}};
      bus_wdata   = q_wdata;
      bus_wb_line = ra_line;
      unique case (st_q)
         F_UPD:  begin bus_cmd = BC_UPDATE; bus_addr = q_addr; end
         F_WB:   begin bus_cmd = BC_WRBACK; bus_addr = {ra_tag, ra_idx, {OFF_W{1'b0}}}; end
         F_FILL: bus_cmd = BC_READ;
         default: bus_req = 1'b0;
      endcase
   end

   always_comb begin
      fw_meta_en = 1'b0;
      fw_present = 1'b1;
      fw_tag     = q_tag;
      fw_state   = ra_state;
      fw_line_en = 1'b0;
      fw_line    = bus_fill_line;
      fw_word_en = 1'b0;
      fw_off     = q_off;
      fw_word    = q_wdata;
      unique case (st_q)
         F_LOOK: if (!stall && look_hit && q_we && own_line) begin
            fw_word_en = 1'b1;
            fw_meta_en = 1'b1;
            fw_state   = CS_MOD;
         end
         F_UPD: if (bus_gnt) begin
            fw_word_en = 1'b1;
            fw_meta_en = 1'b1;
            fw_state   = bus_shared ? CS_SHMOD : CS_MOD;
         end
         F_WB: if (bus_gnt) begin
            fw_meta_en = 1'b1;
            fw_present = 1'b0;
         end
         F_FILL: if (bus_gnt) begin
            fw_meta_en = 1'b1;
            fw_line_en = 1'b1;
            fw_state   = bus_shared ? CS_SHCLN : CS_EXCL;
         end
         default: ;
      endcase
      fw_en = fw_meta_en || fw_word_en || fw_line_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= F_IDLE;
         q_we      <= 1'b0;
         q_addr    <= '0;
         q_wdata   <= '0;
         cpu_done  <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         cpu_done <= 1'b0;
         unique case (st_q)
            F_IDLE: if (cpu_req) begin
               q_we    <= cpu_we;
               q_addr  <= cpu_addr;
               q_wdata <= cpu_wdata;
               st_q    <= F_LOOK;
            end
            F_LOOK: if (!stall) begin
               if (look_hit) begin
                  if (!q_we) begin
                     cpu_rdata <= ra_line[q_off*WORD_W +: WORD_W];
                     cpu_done  <= 1'b1;
                     st_q      <= F_IDLE;
                  end else if (own_line) begin
                     cpu_done <= 1'b1;
                     st_q     <= F_IDLE;
                  end else begin
                     st_q <= F_UPD;
                  end
               end else if (ra_present && st_dirty(ra_state)) begin
                  st_q <= F_WB;
               end else begin
                  st_q <= F_FILL;
               end
            end
            F_UPD: if (bus_gnt) begin
               cpu_done <= 1'b1;
               st_q     <= F_IDLE;
            end
            F_WB:   if (bus_gnt) st_q <= F_FILL;
            F_FILL: if (bus_gnt) st_q <= F_LOOK;
            default: st_q <= F_IDLE;
         endcase
      end
   end

   // R11: a snoop holds the lookup in place
   a_r11_look_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == F_LOOK && stall) |=> (st_q == F_LOOK));

   // R2: an ungranted request keeps its command and address
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

   // R9: a granted write-back is followed directly by the line read
   a_r9_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == BC_WRBACK && bus_gnt) |=> (bus_req && bus_cmd == BC_READ));

   // R3: completion is a single-cycle pulse
   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R1: an idle controller requests nothing on the bus
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !bus_req);

endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
   import upd_coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int WORD_W = 32,
   parameter int WORDS  = 4,
   parameter int LINES  = 4,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int IDX_W  = $clog2(LINES),
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
   localparam int LINE_W = WORD_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [WORD_W-1:0] bus_wdata,
   output logic [LINE_W-1:0] bus_wb_line,
   input  logic              bus_gnt,
   input  logic              bus_shared,
   input  logic [LINE_W-1:0] bus_fill_line,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [WORD_W-1:0] snp_word,
   output logic              snp_hit_shared,
   output logic              snp_flush,
   output logic [LINE_W-1:0] snp_flush_line
);

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two and at least 2");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two and at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits");
   end

   logic [IDX_W-1:0]  ra_idx, rb_idx;
   logic              ra_present, rb_present;
   logic [TAG_W-1:0]  ra_tag, rb_tag;
   coh_state_e        ra_state, rb_state;
   logic [LINE_W-1:0] ra_line, rb_line;
   bus_cmd_e          bus_cmd_t;

   logic              sw_en, sw_meta_en, sw_word_en;
   coh_state_e        sw_state;
   logic [OFF_W-1:0]  sw_off;
   logic [WORD_W-1:0] sw_word;

   logic              fw_en, fw_meta_en, fw_present, fw_line_en, fw_word_en;
   logic [TAG_W-1:0]  fw_tag;
   coh_state_e        fw_state;
   logic [LINE_W-1:0] fw_line;
   logic [OFF_W-1:0]  fw_off;
   logic [WORD_W-1:0] fw_word;

   logic              w_en, w_meta_en, w_present, w_line_en, w_word_en;
   logic [IDX_W-1:0]  w_idx;
   logic [TAG_W-1:0]  w_tag;
   coh_state_e        w_state;
   logic [OFF_W-1:0]  w_off;
   logic [WORD_W-1:0] w_word;

   assign bus_cmd = bus_cmd_t;

   // Snoop writes win the single array write port.
   always_comb begin
      if (sw_en) begin
         w_en      = 1'b1;
         w_idx     = rb_idx;
         w_meta_en = sw_meta_en;
         w_present = 1'b1;
         w_tag     = rb_tag;
         w_state   = sw_state;
         w_line_en = 1'b0;
         w_word_en = sw_word_en;
         w_off     = sw_off;
         w_word    = sw_word;
      end else begin
         w_en      = fw_en;
         w_idx     = ra_idx;
         w_meta_en = fw_meta_en;
         w_present = fw_present;
         w_tag     = fw_tag;
         w_state   = fw_state;
         w_line_en = fw_line_en;
         w_word_en = fw_word_en;
         w_off     = fw_off;
         w_word    = fw_word;
      end
   end

   coh_line_array #(
      .LINES(LINES), .TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .ra_idx(ra_idx), .ra_present(ra_present), .ra_tag(ra_tag),
      .ra_state(ra_state), .ra_line(ra_line),
      .rb_idx(rb_idx), .rb_present(rb_present), .rb_tag(rb_tag),
      .rb_state(rb_state), .rb_line(rb_line),
      .w_en(w_en), .w_idx(w_idx), .w_meta_en(w_meta_en), .w_present(w_present),
      .w_tag(w_tag), .w_state(w_state), .w_line_en(w_line_en), .w_line(fw_line),
      .w_word_en(w_word_en), .w_off(w_off), .w_word(w_word)
   );

   coh_snoop_unit #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .LINES(LINES)
   ) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_word(snp_word),
      .rb_idx(rb_idx), .rb_present(rb_present), .rb_tag(rb_tag),
      .rb_state(rb_state), .rb_line(rb_line),
      .sw_en(sw_en), .sw_meta_en(sw_meta_en), .sw_state(sw_state),
      .sw_word_en(sw_word_en), .sw_off(sw_off), .sw_word(sw_word),
      .snp_hit_shared(snp_hit_shared), .snp_flush(snp_flush),
      .snp_flush_line(snp_flush_line)
   );

   coh_req_fsm #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .LINES(LINES)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
      .cpu_rdata(cpu_rdata), .stall(snp_valid),
      .ra_idx(ra_idx), .ra_present(ra_present), .ra_tag(ra_tag),
      .ra_state(ra_state), .ra_line(ra_line),
      .bus_req(bus_req), .bus_cmd(bus_cmd_t), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wb_line(bus_wb_line), .bus_gnt(bus_gnt),
      .bus_shared(bus_shared), .bus_fill_line(bus_fill_line),
      .fw_en(fw_en), .fw_meta_en(fw_meta_en), .fw_present(fw_present),
      .fw_tag(fw_tag), .fw_state(fw_state), .fw_line_en(fw_line_en),
      .fw_line(fw_line), .fw_word_en(fw_word_en), .fw_off(fw_off),
      .fw_word(fw_word)
   );

   // R11: one bus, so a grant and a snoop never share a cycle
   a_r11_single_bus_use: assert property (@(posedge clk) disable iff (!rst_n)
      !(snp_valid && bus_gnt));

endmodule

// File: tb/sim_upd_coh_ctrl.sv
module sim_upd_coh_ctrl;
   import upd_coh_pkg::*;

   localparam int AW = 12;
   localparam int DW = 32;
   localparam int LW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready, cpu_done;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [LW-1:0] bus_wb_line;
   logic          bus_gnt = 1'b0, bus_shared = 1'b0;
   logic [LW-1:0] bus_fill_line = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic [DW-1:0] snp_word = '0;
   logic          snp_hit_shared, snp_flush;
   logic [LW-1:0] snp_flush_line;

   always #2 clk = ~clk;

   upd_coh_ctrl u0 (.*);

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 1'b0;

   int            n_tx;
   logic [1:0]    tx_cmd  [4];
   logic [AW-1:0] tx_addr [4];
   logic [DW-1:0] tx_data [4];
   logic [LW-1:0] tx_line [4];
   logic [DW-1:0] rd;
   logic          s_sh, s_fl;
   logic [LW-1:0] s_line;

   function automatic logic [LW-1:0] fill_of(logic [AW-1:0] a);
      logic [LW-1:0] l;
      logic [AW-1:0] la;
      la = a & ~AW'(3);
      for (int i = 0; i < 4; i++)
         l[i*DW +: DW] = 32'hC0DE_0000 | (32'(la) << 4) | 32'(i);
      return l;
   endfunction

   task automatic chk(input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic cpu_op(input logic we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic sh);
      bit got = 1'b0;
      n_tx = 0;
      rd = '0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0;
      for (int t = 0; t < 100 && !got; t++) begin
         logic was_g;
         was_g = bus_gnt;
         bus_gnt = 1'b0;
         if (cpu_done) begin
            got = 1'b1;
            rd = cpu_rdata;
         end else begin
            if (!was_g && bus_req) begin
               if (n_tx < 4) begin
                  tx_cmd[n_tx]  = bus_cmd;
                  tx_addr[n_tx] = bus_addr;
                  tx_data[n_tx] = bus_wdata;
                  tx_line[n_tx] = bus_wb_line;
               end
               n_tx++;
               bus_gnt = 1'b1;
               bus_shared = sh;
               bus_fill_line = fill_of(bus_addr);
            end
            @(negedge clk);
         end
      end
      chk("completion of processor request", LW'(got), LW'(1));
   endtask

   task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] w);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_word = w;
      #1 s_sh = snp_hit_shared;
      @(negedge clk);
      snp_valid = 1'b0;
      s_fl = snp_flush;
      s_line = snp_flush_line;
   endtask

   task automatic t_reset;
      chk("R1 ready after reset", LW'(cpu_ready), LW'(1));
      chk("R1 no bus request after reset", LW'(bus_req), LW'(0));
      chk("R1 no done after reset", LW'(cpu_done), LW'(0));
      chk("R1 no flush after reset", LW'(snp_flush), LW'(0));
      snoop(2'd1, 12'h010, '0);
      chk("R1 empty array reports no sharer", LW'(s_sh), LW'(0));
   endtask

   task automatic t_read_miss_hit;
      cpu_op(1'b0, 12'h123, '0, 1'b0);
      chk("R2 one transaction on read miss", LW'(n_tx), LW'(1));
      chk("R2 bus read command", LW'(tx_cmd[0]), LW'(1));
      chk("R2 line-aligned read address", LW'(tx_addr[0]), LW'(12'h120));
      chk("R2 fill word returned", LW'(rd), LW'(32'hC0DE1203));
      cpu_op(1'b0, 12'h121, '0, 1'b0);
      chk("R3 read hit uses no bus", LW'(n_tx), LW'(0));
      chk("R3 read hit data", LW'(rd), LW'(32'hC0DE1201));
   endtask

   task automatic t_silent_write;
      cpu_op(1'b1, 12'h122, 32'hD000_0001, 1'b0);
      chk("R4 exclusive write is silent", LW'(n_tx), LW'(0));
      cpu_op(1'b0, 12'h122, '0, 1'b0);
      chk("R4 written word read back", LW'(rd), LW'(32'hD000_0001));
   endtask

   task automatic t_snoop_flush;
      snoop(2'd1, 12'h120, '0);
      chk("R7 hit raises shared wire", LW'(s_sh), LW'(1));
      chk("R6 modified line flushed", LW'(s_fl), LW'(1));
      chk("R6 flush carries written word", LW'(s_line[64 +: DW]), LW'(32'hD000_0001));
      snoop(2'd1, 12'h123, '0);
      chk("R6 shared-modified flushes again", LW'(s_fl), LW'(1));
      chk("R6 flush word 3", LW'(s_line[96 +: DW]), LW'(32'hC0DE1203));
   endtask

   task automatic t_update_writes;
      cpu_op(1'b1, 12'h120, 32'hD000_0002, 1'b1);
      chk("R5 shared write issues one transaction", LW'(n_tx), LW'(1));
      chk("R5 update command", LW'(tx_cmd[0]), LW'(2));
      chk("R5 update word address", LW'(tx_addr[0]), LW'(12'h120));
      chk("R5 update word", LW'(tx_data[0]), LW'(32'hD000_0002));
      snoop(2'd1, 12'h120, '0);
      chk("R5 shared at grant keeps shared-modified", LW'(s_fl), LW'(1));
      chk("R5 updated word in line", LW'(s_line[0 +: DW]), LW'(32'hD000_0002));
      cpu_op(1'b1, 12'h121, 32'hD000_0003, 1'b0);
      chk("R5 update with no sharer", LW'(n_tx), LW'(1));
      cpu_op(1'b1, 12'h121, 32'hD000_0004, 1'b0);
      chk("R5 no sharer left line modified", LW'(n_tx), LW'(0));
   endtask

   task automatic t_snoop_update;
      snoop(2'd1, 12'h120, '0);
      chk("R6 modified to shared-modified flush", LW'(s_fl), LW'(1));
      snoop(2'd2, 12'h121, 32'hBEEF_0000);
      chk("R8 update hit raises shared wire", LW'(s_sh), LW'(1));
      chk("R8 update causes no flush", LW'(s_fl), LW'(0));
      cpu_op(1'b0, 12'h121, '0, 1'b0);
      chk("R8 snooped word stored", LW'(rd), LW'(32'hBEEF_0000));
      chk("R8 read of stored word is local", LW'(n_tx), LW'(0));
      snoop(2'd1, 12'h120, '0);
      chk("R8 shared-clean no longer flushes", LW'(s_fl), LW'(0));
      cpu_op(1'b0, 12'h523, '0, 1'b0);
      chk("R9 clean victim only reads", LW'(n_tx), LW'(1));
      chk("R9 clean victim read command", LW'(tx_cmd[0]), LW'(1));
      chk("R9 new line data", LW'(rd), LW'(32'hC0DE5203));
   endtask

   task automatic t_shared_fill;
      cpu_op(1'b0, 12'h234, '0, 1'b1);
      chk("R2 shared fill read address", LW'(tx_addr[0]), LW'(12'h234));
      chk("R2 shared fill data", LW'(rd), LW'(32'hC0DE2340));
      cpu_op(1'b1, 12'h235, 32'hD000_0005, 1'b0);
      chk("R2 shared-clean fill makes write update", LW'(n_tx), LW'(1));
      chk("R2 update command after shared fill", LW'(tx_cmd[0]), LW'(2));
   endtask

   task automatic t_dirty_victim;
      cpu_op(1'b0, 12'h634, '0, 1'b0);
      chk("R9 dirty victim two transactions", LW'(n_tx), LW'(2));
      chk("R9 write-back first", LW'(tx_cmd[0]), LW'(3));
      chk("R9 write-back address", LW'(tx_addr[0]), LW'(12'h234));
      chk("R9 write-back data", LW'(tx_line[0][32 +: DW]), LW'(32'hD000_0005));
      chk("R9 read follows", LW'(tx_cmd[1]), LW'(1));
      chk("R9 read address", LW'(tx_addr[1]), LW'(12'h634));
      chk("R9 read data", LW'(rd), LW'(32'hC0DE6340));
   endtask

   task automatic t_excl_to_shared;
      cpu_op(1'b0, 12'h348, '0, 1'b0);
      snoop(2'd1, 12'h348, '0);
      chk("R7 exclusive hit raises shared wire", LW'(s_sh), LW'(1));
      chk("R7 exclusive line not flushed", LW'(s_fl), LW'(0));
      cpu_op(1'b1, 12'h349, 32'hD000_0006, 1'b0);
      chk("R7 line now shared, write updates", LW'(n_tx), LW'(1));
      chk("R7 update address", LW'(tx_addr[0]), LW'(12'h349));
   endtask

   task automatic t_snoop_miss;
      snoop(2'd1, 12'h748, '0);
      chk("R10 miss read no shared wire", LW'(s_sh), LW'(0));
      chk("R10 miss read no flush", LW'(s_fl), LW'(0));
      snoop(2'd2, 12'h749, 32'h1111_1111);
      chk("R10 miss update no shared wire", LW'(s_sh), LW'(0));
      cpu_op(1'b0, 12'h349, '0, 1'b0);
      chk("R10 missed update leaves data", LW'(rd), LW'(32'hD000_0006));
   endtask

   task automatic t_shmod_victim;
      cpu_op(1'b0, 12'h0CC, '0, 1'b0);
      cpu_op(1'b1, 12'h0CD, 32'hD000_0007, 1'b0);
      chk("R4 second silent write", LW'(n_tx), LW'(0));
      snoop(2'd1, 12'h0CC, '0);
      chk("R6 flush before replacement", LW'(s_fl), LW'(1));
      cpu_op(1'b0, 12'h8CC, '0, 1'b0);
      chk("R9 shared-modified victim written back", LW'(tx_cmd[0]), LW'(3));
      chk("R9 shared-modified write-back data", LW'(tx_line[0][32 +: DW]), LW'(32'hD000_0007));
      chk("R9 read after write-back", LW'(tx_addr[1]), LW'(12'h8CC));
   endtask

   task automatic t_snoop_priority;
      // R11: a snoop presented with a new request delays the lookup
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 12'h8CD;
      @(negedge clk);
      cpu_req = 1'b0;
      snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 12'h8CC;
      @(negedge clk);
      chk("R11 no completion while snoop present", LW'(cpu_done), LW'(0));
      snp_valid = 1'b0;
      @(negedge clk);
      chk("R11 completion after snoop", LW'(cpu_done), LW'(1));
      chk("R11 data after snoop", LW'(cpu_rdata), LW'(32'hC0DE8CC1));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_miss_hit();
      t_silent_write();
      t_snoop_flush();
      t_update_writes();
      t_snoop_update();
      t_shared_fill();
      t_dirty_victim();
      t_excl_to_shared();
      t_snoop_miss();
      t_shmod_victim();
      t_snoop_priority();
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule